// File: doc/BRIEF.md
# DRAM Request Splitter

This block sits between an application port and a DRAM bank controller. The application hands it a transfer made of a byte address, a length counted in memory words, a wrap flag and a direction flag. The block turns that transfer into one or more pieces. A piece never runs past the end of a column page. For each piece it works out the bank, row and column, and offers the piece to the bank controller over a valid/acknowledge handshake.

The column width and the memory data width come from live configuration inputs. The number of bank-select address bits also comes from a live input. All three set how the word address is cut into fields. A wrap transfer is never split: it goes out as a single piece of fixed length four, and the device wraps it inside its burst.

The first piece of each transfer carries a start marker and the final piece carries an end marker. Every piece repeats the direction flag and the wrap flag. The configuration inputs must stay unchanged while a transfer is in progress.

Top module: `dram_req_splitter`

## Requirements
- R1: The column field is the low `8 + col_sel` bits of the word address, so col_sel 00/01/10/11 gives 8/9/10/11 column bits. The field is zero-extended to 12 bits on `sub_col`.
- R2: The word address is the byte address shifted right by the memory width setting: mem_width 00 (4-byte word) shifts by 2, 01 (2-byte word) shifts by 1, and 10 or 11 (1-byte word) shifts by 0.
- R3: With `four_bank` = 1 the bank is the 2 word-address bits just above the column. With `four_bank` = 0 it is the single bit above the column, and `sub_bank[1]` is 0.
- R4: The row is the next 12 word-address bits above the bank bits.
- R5: For a non-wrap transfer, each piece's length is the smaller of the words still owed and the words left to the page end (2^colbits minus column). Each later piece starts at the word following the previous piece. The requested length must be nonzero.
- R6: A wrap transfer produces exactly one piece of length 4 with `sub_wrap` set, whatever `req_len` holds.
- R7: `sub_first` is 1 only on the first piece of a transfer. `sub_last` is 1 only on its final piece. `sub_write` repeats `req_write`.
- R8: `req_ack` is high, in the same cycle, exactly when `req_valid` is high and no transfer is in progress. The transfer is captured at that clock edge. While a transfer is in progress `req_ack` stays low.
- R9: The first piece appears on the cycle after the capture. A piece holds all of its fields stable while `sub_ack` is low. The next piece appears on the cycle after `sub_ack`.
- R10: `idle` is high and `sub_valid` is low after reset and on the cycle after the final piece is acknowledged. `idle` is low while pieces are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| col_sel | input | 2 | Column width setting (8 + value bits) |
| mem_width | input | 2 | Memory word size: 00 = 4 bytes, 01 = 2 bytes, 1x = 1 byte |
| four_bank | input | 1 | 1 = two bank bits, 0 = one bank bit |
| req_valid | input | 1 | Application transfer offered |
| req_addr | input | 28 | Byte address |
| req_len | input | 12 | Length in memory words (nonzero) |
| req_wrap | input | 1 | Wrap transfer, single piece of 4 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ack | output | 1 | Transfer accepted this cycle |
| sub_valid | output | 1 | Piece offered to the bank controller |
| sub_ack | input | 1 | Bank controller takes the piece |
| sub_bank | output | 2 | Bank of the piece |
| sub_row | output | 12 | Row of the piece |
| sub_col | output | 12 | Start column of the piece |
| sub_len | output | 12 | Piece length in words |
| sub_write | output | 1 | Direction of the piece |
| sub_first | output | 1 | First piece of the transfer |
| sub_last | output | 1 | Final piece of the transfer |
| sub_wrap | output | 1 | Piece belongs to a wrap transfer |
| idle | output | 1 | No transfer pending |

## Verification
A wrong running word address or remaining count shows up on the second piece of a transfer. It appears as a column that does not start at zero, or as a length that does not add up to the requested total. Either is visible one cycle after the first acknowledge. A stuck progress flag shows as `sub_first` repeating, or as `idle` failing to return on the cycle after the final acknowledge. Field-cutting errors show as a wrong bank or row on the very first piece. These are exposed by sweeping every column width, memory width and bank count with addresses placed at and near page ends.

// File: rtl/rsplit_pkg.sv
package rsplit_pkg;
    parameter int ADDR_W   = 28;
    parameter int LEN_W    = 12;
    parameter int ROW_W    = 12;
    parameter int COL_W    = 12;
    parameter int BANK_W   = 2;
    parameter int MIN_COL  = 8;
    parameter int WRAP_LEN = 4;
    localparam int LEFT_W  = COL_W + 1;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } loc_t;

    function automatic int unsigned col_bits(logic [1:0] sel);
        return MIN_COL + int'(sel);
    endfunction

    function automatic int unsigned byte_shift(logic [1:0] w);
        case (w)
            2'b00:   return 2;
            2'b01:   return 1;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/rsplit_decode.sv
module rsplit_decode
    import rsplit_pkg::*;
(
    input  logic [ADDR_W-1:0] word,
    input  logic [1:0]        col_sel,
    input  logic              four_bank,
    output loc_t              loc,
    output logic [LEFT_W-1:0] page_left
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    int unsigned       cb;
    int unsigned       bb;
    logic [ADDR_W-1:0] cmask;
    logic [ADDR_W-1:0] above;
    logic [ADDR_W-1:0] bmask;

    always_comb begin
        cb    = col_bits(col_sel);
        bb    = four_bank ? 2 : 1;
        cmask = (ONE << cb) - ONE;
        bmask = (ONE << bb) - ONE;
        above = word >> cb;
        loc.col  = COL_W'(word & cmask);
        loc.bank = BANK_W'(above & bmask);
        loc.row  = ROW_W'(above >> bb);
        page_left = LEFT_W'(ONE << cb) - LEFT_W'(word & cmask);
    end
endmodule

// File: rtl/rsplit_size.sv
module rsplit_size
    import rsplit_pkg::*;
(
    input  logic [LEN_W-1:0]  remaining,
    input  logic [LEFT_W-1:0] page_left,
    input  logic              wrap,
    output logic [LEN_W-1:0]  len,
    output logic              is_last
);
    localparam int CMP_W = (LEN_W > LEFT_W) ? LEN_W : LEFT_W;

    logic [CMP_W-1:0] rem_x;
    logic [CMP_W-1:0] left_x;

    always_comb begin
        rem_x  = CMP_W'(remaining);
        left_x = CMP_W'(page_left);
        if (wrap) begin
            len     = LEN_W'(WRAP_LEN);
            is_last = 1'b1;
        end else if (rem_x <= left_x) begin
            len     = remaining;
            is_last = 1'b1;
        end else begin
            len     = LEN_W'(left_x);
            is_last = 1'b0;
        end
    end
endmodule

// File: rtl/dram_req_splitter.sv
module dram_req_splitter
    import rsplit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        col_sel,
    input  logic [1:0]        mem_width,
    input  logic              four_bank,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_wrap,
    input  logic              req_write,
    output logic              req_ack,
    output logic              sub_valid,
    input  logic              sub_ack,
    output logic [BANK_W-1:0] sub_bank,
    output logic [ROW_W-1:0]  sub_row,
    output logic [COL_W-1:0]  sub_col,
    output logic [LEN_W-1:0]  sub_len,
    output logic              sub_write,
    output logic              sub_first,
    output logic              sub_last,
    output logic              sub_wrap,
    output logic              idle
);
    logic              busy_q;
    logic [ADDR_W-1:0] word_q;
    logic [LEN_W-1:0]  rem_q;
    logic              write_q;
    logic              wrap_q;
    logic              first_q;

    loc_t              loc;
    logic [LEFT_W-1:0] page_left;
    logic [LEN_W-1:0]  piece_len;
    logic              piece_last;

    rsplit_decode u_decode (
        .word      (word_q),
        .col_sel   (col_sel),
        .four_bank (four_bank),
        .loc       (loc),
        .page_left (page_left)
    );

    rsplit_size u_size (
        .remaining (rem_q),
        .page_left (page_left),
        .wrap      (wrap_q),
        .len       (piece_len),
        .is_last   (piece_last)
    );

    assign req_ack   = req_valid && !busy_q;
    assign sub_valid = busy_q;
    assign idle      = !busy_q;
    assign sub_bank  = loc.bank;
    assign sub_row   = loc.row;
    assign sub_col   = loc.col;
    assign sub_len   = piece_len;
    assign sub_write = write_q;
    assign sub_first = first_q;
    assign sub_last  = piece_last;
    assign sub_wrap  = wrap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            word_q  <= '0;
            rem_q   <= '0;
            write_q <= 1'b0;
            wrap_q  <= 1'b0;
            first_q <= 1'b0;
        end else if (!busy_q) begin
            if (req_valid) begin
                busy_q  <= 1'b1;
                word_q  <= req_addr >> byte_shift(mem_width);
                rem_q   <= req_wrap ? LEN_W'(WRAP_LEN) : req_len;
                write_q <= req_write;
                wrap_q  <= req_wrap;
                first_q <= 1'b1;
            end
        end else if (sub_ack) begin
            if (piece_last) begin
                busy_q <= 1'b0;
            end else begin
                word_q  <= word_q + ADDR_W'(piece_len);
                rem_q   <= rem_q - piece_len;
                first_q <= 1'b0;
            end
        end
    end

    // R8: a capture is followed by a first piece
    p_capture_r8: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> (sub_valid && sub_first));

    // R9: a stalled piece keeps every field
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (sub_valid && !sub_ack) |=> (sub_valid &&
            $stable({sub_bank, sub_row, sub_col, sub_len, sub_write,
                     sub_first, sub_last, sub_wrap})));

    // R5: a non-wrap piece stays inside its page and is never empty
    p_in_page_r5: assert property (@(posedge clk) disable iff (rst)
        (sub_valid && !sub_wrap) |->
            ((14'(sub_col) + 14'(sub_len) <= (14'd1 << col_bits(col_sel)))
             && (sub_len != '0)));

    // R6: a wrap transfer is one piece of fixed length
    p_wrap_single_r6: assert property (@(posedge clk) disable iff (rst)
        (sub_valid && sub_wrap) |->
            (sub_len == LEN_W'(WRAP_LEN) && sub_first && sub_last));

    // R10: acknowledging the final piece returns the block to idle
    p_done_r10: assert property (@(posedge clk) disable iff (rst)
        (sub_valid && sub_ack && sub_last) |=> (idle && !sub_valid));

    // R7: an acknowledged piece that is not final is followed by a non-first one
    p_follow_r7: assert property (@(posedge clk) disable iff (rst)
        (sub_valid && sub_ack && !sub_last) |=> (sub_valid && !sub_first));
endmodule

// File: tb/dram_req_splitter_test.sv
module dram_req_splitter_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  col_sel;
    logic [1:0]  mem_width;
    logic        four_bank;
    logic        req_valid;
    logic [27:0] req_addr;
    logic [11:0] req_len;
    logic        req_wrap;
    logic        req_write;
    logic        req_ack;
    logic        sub_valid;
    logic        sub_ack;
    logic [1:0]  sub_bank;
    logic [11:0] sub_row;
    logic [11:0] sub_col;
    logic [11:0] sub_len;
    logic        sub_write;
    logic        sub_first;
    logic        sub_last;
    logic        sub_wrap;
    logic        idle;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    dram_req_splitter uut (
        .clk(clk), .rst(rst), .col_sel(col_sel), .mem_width(mem_width),
        .four_bank(four_bank), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_wrap(req_wrap), .req_write(req_write),
        .req_ack(req_ack), .sub_valid(sub_valid), .sub_ack(sub_ack),
        .sub_bank(sub_bank), .sub_row(sub_row), .sub_col(sub_col),
        .sub_len(sub_len), .sub_write(sub_write), .sub_first(sub_first),
        .sub_last(sub_last), .sub_wrap(sub_wrap), .idle(idle)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_piece(input longint word, input int cb, input int bb,
                               input int plen, input bit first, input bit last,
                               input bit wr, input bit wrap, input string when);
        longint col, bank, row;
        col  = word % (64'd1 << cb);
        bank = (word >> cb) & ((64'd1 << bb) - 1);
        row  = (word >> (cb + bb)) & 64'hFFF;
        chk(sub_valid == 1'b1, {"R9 valid ", when}, sub_valid, 1);
        chk(sub_col == 12'(col), {"R1 R2 column ", when}, sub_col, col);
        chk(sub_bank == 2'(bank), {"R3 bank ", when}, sub_bank, bank);
        chk(sub_row == 12'(row), {"R4 row ", when}, sub_row, row);
        chk(sub_len == 12'(plen), {"R5 R6 length ", when}, sub_len, plen);
        chk(sub_first == first && sub_last == last && sub_write == wr,
            {"R7 markers ", when}, {sub_first, sub_last, sub_write},
            {first, last, wr});
        chk(sub_wrap == wrap, {"R6 wrap flag ", when}, sub_wrap, wrap);
    endtask

    // Issue one transfer at a negedge and follow all its pieces
    task automatic run_req(input longint baddr, input int len, input bit wrap,
                           input bit wr, input bit stall);
        int     shift, cb, bb, rem, plen, idx;
        longint word, left;
        bit     first, last;
        shift = (mem_width == 2'b00) ? 2 : (mem_width == 2'b01) ? 1 : 0;
        cb    = 8 + int'(col_sel);
        bb    = four_bank ? 2 : 1;
        word  = baddr >> shift;
        rem   = wrap ? 4 : len;
        first = 1'b1;
        idx   = 0;
        req_valid = 1'b1; req_addr = 28'(baddr); req_len = 12'(len);
        req_wrap = wrap; req_write = wr;
        #1;
        chk(req_ack == 1'b1, "R8 ack when idle", req_ack, 1);
        @(negedge clk);
        req_valid = 1'b0; req_len = 12'd7;
        do begin
            left = (64'd1 << cb) - (word % (64'd1 << cb));
            if (wrap) plen = 4;
            else plen = (longint'(rem) <= left) ? rem : int'(left);
            last = wrap || (plen == rem);
            #1;
            check_piece(word, cb, bb, plen, first, last, wr, wrap, "offer");
            if (first) begin
                req_valid = 1'b1;
                #1;
                chk(req_ack == 1'b0, "R8 no ack while busy", req_ack, 0);
                chk(idle == 1'b0, "R10 busy not idle", idle, 0);
                req_valid = 1'b0;
            end
            if (stall && idx[0] == 1'b0) begin
                sub_ack = 1'b0;
                @(negedge clk);
                #1;
                check_piece(word, cb, bb, plen, first, last, wr, wrap, "stalled");
            end
            sub_ack = 1'b1;
            @(negedge clk);
            sub_ack = 1'b0;
            word  = word + plen;
            rem   = rem - plen;
            first = 1'b0;
            idx++;
        end while (!last);
        #1;
        chk(idle == 1'b1 && sub_valid == 1'b0, "R10 idle after final", {idle, sub_valid}, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; col_sel = 2'b00; mem_width = 2'b00; four_bank = 1'b1;
        req_valid = 1'b0; req_addr = '0; req_len = 12'd1; req_wrap = 1'b0;
        req_write = 1'b0; sub_ack = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(idle == 1'b1 && sub_valid == 1'b0 && req_ack == 1'b0,
            "R10 reset state", {idle, sub_valid, req_ack}, 4);
        rst = 1'b0;
        @(negedge clk);
        for (int w = 0; w < 4; w++) begin
            for (int cs = 0; cs < 4; cs++) begin
                for (int fb = 0; fb < 2; fb++) begin
                    int     shift, cb, bb, pg, n;
                    longint row, bank, base;
                    mem_width = 2'(w); col_sel = 2'(cs); four_bank = fb[0];
                    shift = (w == 0) ? 2 : (w == 1) ? 1 : 0;
                    cb = 8 + cs; bb = fb ? 2 : 1; pg = 1 << cb;
                    n    = w * 8 + cs * 2 + fb;
                    row  = (n * 397 + 5) % 4096;
                    bank = n % (1 << bb);
                    base = (row << (cb + bb)) | (bank << cb);
                    // near page end, crosses into the next bank
                    run_req(((base | longint'(pg - 3)) << shift) | longint'(n % (1 << shift)),
                            10, 1'b0, n[0], 1'b1);
                    // mid page, more than one page long
                    run_req((base | 5) << shift, pg + 20, 1'b0, 1'b1, n[1]);
                    // wrap ignores the requested length
                    run_req((base | longint'(pg - 2)) << shift, 100, 1'b1, 1'b0, 1'b1);
                    // exact page fit gives one final piece
                    run_req(base << shift, pg, 1'b0, 1'b0, 1'b0);
                    // single word at the last column
                    run_req((base | longint'(pg - 1)) << shift, 1, 1'b0, 1'b1, 1'b0);
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule